// File: doc/BRIEF.md
# Command Unlock Sequence Detector

This block sits beside the array of an asynchronous-style memory. It watches each access as a single-cycle valid pulse that carries the address, a write level and the output-enable level. Six reads must arrive in a fixed order before the block issues anything. The first five reads must hit a fixed prefix of addresses. The sixth read selects the command: one address gives a store command and another gives a recall command. The command goes to a separate sequencer as a one-cycle pulse.

Once a command is recognised, the block floats the data bus, starting with the sixth access itself. The bus stays floated while the sequencer reports busy. While the bus is floated, every access is ignored and the sequence position is held at zero. The block computes the drive-enable for the read data, so the first five reads of a sequence still return data normally.

Top module: `nvcmd_seq_detect`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `store_cmd`, `recall_cmd`, `bus_float` and `dq_drive` are all 0. Reset also discards any partly entered sequence.
- R2: The store command is six reads in order to 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0. It raises `store_cmd` for exactly one cycle, the cycle after the sixth access.
- R3: The recall command is the same five-read prefix followed by a read of 0x0C63. It raises `recall_cmd` for exactly one cycle, the cycle after the sixth access.
- R4: An access with `acc_write`=1 at any position, the sixth included, cancels the sequence, and no command follows.
- R5: A read whose address is not the expected one cancels the sequence, and no command follows. If that read is to 0x0E38, it counts as the first step of a new sequence.
- R6: Only `acc_addr[13:0]` are compared. Bit 14 never changes the outcome.
- R7: `acc_oe` has no effect on detection. A read with `acc_oe`=0 still advances the sequence.
- R8: `bus_float` is 1 during a sixth access that completes a command, in the cycle after it, and in every later cycle up to and including the cycle after `seq_busy` falls. The cycle after the sixth access is also the cycle of the command pulse. In all other cycles, `bus_float` is 1 exactly when `seq_busy` is 1.
- R9: `dq_drive` equals `acc_valid & ~acc_write & acc_oe & ~bus_float`. The first five accesses of a sequence are therefore driven like any other read.
- R10: An access is ignored in any cycle where `seq_busy` is 1 or the bus is still floated from a previous command. An ignored access leaves the sequence at its start, so a full six-read sequence is needed afterwards.
- R11: `store_cmd` and `recall_cmd` are never 1 in the same cycle.
- R12: Cycles with `acc_valid`=0 between steps do not cancel a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | One-cycle pulse marking an access |
| acc_addr | input | ADDR_W (15) | Access address; bits 13..0 are compared |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| acc_oe | input | 1 | Output-enable level of the access |
| seq_busy | input | 1 | Sequencer is executing a command |
| store_cmd | output | 1 | One-cycle store request |
| recall_cmd | output | 1 | One-cycle recall request |
| bus_float | output | 1 | Data bus must be released |
| dq_drive | output | 1 | Drive read data onto the bus this cycle |

## Verification
Two events can fall on the same access. The first is a cancel and a restart: a wrong read at step three that targets 0x0E38 must both cancel the sequence and become step one. The bench then completes a recall from that point and expects the recall pulse. The second is busy arriving on the very access that would complete a store. The bench raises `seq_busy` together with the sixth read and expects no store pulse, together with a floated bus in that cycle only.

// File: rtl/nvcmd_pkg.sv
package nvcmd_pkg;

  // Number of compared address bits and the length of the shared prefix.
  localparam int KEY_W      = 14;
  localparam int PREFIX_LEN = 5;
  localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

  localparam logic [KEY_W-1:0] STORE_KEY  = 14'h0FC0;
  localparam logic [KEY_W-1:0] RECALL_KEY = 14'h0C63;

  // Address expected at position idx of the prefix (0 = first read).
  function automatic logic [KEY_W-1:0] prefix_key(input int idx);
    case (idx)
      0:       return 14'h0E38;
      1:       return 14'h31C7;
      2:       return 14'h03E0;
      3:       return 14'h3C1F;
      4:       return 14'h303F;
      default: return '0;
    endcase
  endfunction

  // Position that follows cur after one access.
  function automatic logic [STEP_W-1:0] step_next(
    input logic [STEP_W-1:0] cur,
    input logic              valid,
    input logic              is_read,
    input logic              ignore,
    input logic              key_ok,
    input logic              restart_ok
  );
    if (ignore)   return '0;
    if (!valid)   return cur;
    if (!is_read) return '0;
    if ((cur != STEP_W'(PREFIX_LEN)) && key_ok) return cur + 1'b1;
    return restart_ok ? STEP_W'(1) : '0;
  endfunction

endpackage

// File: rtl/nvcmd_addr_match.sv
module nvcmd_addr_match
  import nvcmd_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [STEP_W-1:0] step,
  output logic              key_ok,
  output logic              restart_ok,
  output logic              store_ok,
  output logic              recall_ok
);

  logic [KEY_W-1:0]      low_addr;
  logic [PREFIX_LEN-1:0] key_hit;

  assign low_addr = addr[KEY_W-1:0];

  genvar gi;
  generate
    for (gi = 0; gi < PREFIX_LEN; gi++) begin : g_key
      assign key_hit[gi] = (low_addr == prefix_key(gi));
    end
  endgenerate

  always_comb begin
    key_ok = 1'b0;
    for (int i = 0; i < PREFIX_LEN; i++) begin
      if (step == STEP_W'(i)) key_ok = key_hit[i];
    end
  end

  assign restart_ok = key_hit[0];
  assign store_ok   = (low_addr == STORE_KEY);
  assign recall_ok  = (low_addr == RECALL_KEY);

endmodule

// File: rtl/nvcmd_step_ctrl.sv
module nvcmd_step_ctrl
  import nvcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_read,
  input  logic              ignore,
  input  logic              key_ok,
  input  logic              restart_ok,
  input  logic              final_ok,
  output logic [STEP_W-1:0] step_q,
  output logic              seq_hit
);

  logic at_last;

  assign at_last = (step_q == STEP_W'(PREFIX_LEN));
  assign seq_hit = acc_valid & acc_read & ~ignore & at_last & final_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_next(step_q, acc_valid, acc_read, ignore,
                                    key_ok, restart_ok);
  end

endmodule

// File: rtl/nvcmd_cmd_out.sv
module nvcmd_cmd_out (
  input  logic clk,
  input  logic rst_n,
  input  logic seq_hit,
  input  logic pick_store,
  input  logic seq_busy,
  output logic store_cmd,
  output logic recall_cmd,
  output logic float_hold
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_cmd  <= 1'b0;
      recall_cmd <= 1'b0;
      float_hold <= 1'b0;
    end else begin
      store_cmd  <= seq_hit &  pick_store;
      recall_cmd <= seq_hit & ~pick_store;
      // Hold across the pulse cycle, then for as long as busy stays high.
      float_hold <= seq_hit | store_cmd | recall_cmd | (float_hold & seq_busy);
    end
  end

endmodule

// File: rtl/nvcmd_seq_detect.sv
module nvcmd_seq_detect
  import nvcmd_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              acc_oe,
  input  logic              seq_busy,
  output logic              store_cmd,
  output logic              recall_cmd,
  output logic              bus_float,
  output logic              dq_drive
);

  logic [STEP_W-1:0] step_q;
  logic key_ok, restart_ok, store_ok, recall_ok;
  logic seq_hit, float_hold, acc_ignore;

  assign acc_ignore = seq_busy | float_hold;

  nvcmd_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .addr       (acc_addr),
    .step       (step_q),
    .key_ok     (key_ok),
    .restart_ok (restart_ok),
    .store_ok   (store_ok),
    .recall_ok  (recall_ok)
  );

  nvcmd_step_ctrl u_step (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_read   (~acc_write),
    .ignore     (acc_ignore),
    .key_ok     (key_ok),
    .restart_ok (restart_ok),
    .final_ok   (store_ok | recall_ok),
    .step_q     (step_q),
    .seq_hit    (seq_hit)
  );

  nvcmd_cmd_out u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .seq_hit    (seq_hit),
    .pick_store (store_ok),
    .seq_busy   (seq_busy),
    .store_cmd  (store_cmd),
    .recall_cmd (recall_cmd),
    .float_hold (float_hold)
  );

  assign bus_float = seq_hit | float_hold | seq_busy;
  assign dq_drive  = acc_valid & ~acc_write & acc_oe & ~bus_float;

endmodule

// File: rtl/nvcmd_seq_detect_chk.sv
module nvcmd_seq_detect_chk
  import nvcmd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic              seq_busy,
  input logic              store_cmd,
  input logic              recall_cmd,
  input logic              bus_float,
  input logic [STEP_W-1:0] step,
  input logic              hit,
  input logic              ignore
);

  assert_store_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    store_cmd |=> !store_cmd);

  assert_recall_after_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    recall_cmd |-> $past(hit));

  assert_write_cancels_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write) |=> (step == '0));

  assert_step_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step <= STEP_W'(PREFIX_LEN));

  assert_float_after_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> bus_float);

  assert_busy_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy || ignore) |=> (step == '0));

  assert_cmd_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_cmd && recall_cmd));

endmodule

bind nvcmd_seq_detect nvcmd_seq_detect_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_write  (acc_write),
  .seq_busy   (seq_busy),
  .store_cmd  (store_cmd),
  .recall_cmd (recall_cmd),
  .bus_float  (bus_float),
  .step       (step_q),
  .hit        (seq_hit),
  .ignore     (acc_ignore)
);

// File: tb/nvcmd_seq_detect_tb.sv
module nvcmd_seq_detect_tb;

  localparam int CLK_P = 10;
  localparam int NV    = 62;

  // Control nibble {valid, write, oe, busy}
  localparam logic [3:0] RD  = 4'b1010;
  localparam logic [3:0] RDZ = 4'b1000;
  localparam logic [3:0] WR  = 4'b1110;
  localparam logic [3:0] IDL = 4'b0000;
  localparam logic [3:0] BRD = 4'b1011;
  localparam logic [3:0] BID = 4'b0001;

  // Row: {ctl[3:0], addr[14:0], exp_store, exp_recall, exp_float, req[3:0]}
  localparam logic [25:0] VEC [NV] = '{
    // R2: store pattern, then float held for the pulse cycle
    {RD, 15'h0E38, 3'b000, 4'd2}, {RD, 15'h31C7, 3'b000, 4'd2},
    {RD, 15'h03E0, 3'b000, 4'd2}, {RD, 15'h3C1F, 3'b000, 4'd2},
    {RD, 15'h303F, 3'b000, 4'd2}, {RD, 15'h0FC0, 3'b101, 4'd2},
    {IDL, 15'h0,   3'b001, 4'd8}, {IDL, 15'h0,   3'b001, 4'd8},
    {IDL, 15'h0,   3'b000, 4'd8},
    // R3 R6 R7: recall with bit 14 set and outputs disabled; then busy (R10)
    {RDZ, 15'h4E38, 3'b000, 4'd6}, {RD, 15'h31C7, 3'b000, 4'd7},
    {RDZ, 15'h03E0, 3'b000, 4'd7}, {RD, 15'h7C1F, 3'b000, 4'd6},
    {RD, 15'h303F, 3'b000, 4'd3},  {RD, 15'h0C63, 3'b011, 4'd3},
    {BRD, 15'h0E38, 3'b001, 4'd10}, {BRD, 15'h31C7, 3'b001, 4'd10},
    {BID, 15'h0,    3'b001, 4'd8},  {RD, 15'h03E0, 3'b001, 4'd8},
    {IDL, 15'h0,    3'b000, 4'd8},
    // R10: the ignored accesses must not have advanced the sequence
    {RD, 15'h3C1F, 3'b000, 4'd10}, {RD, 15'h303F, 3'b000, 4'd10},
    {RD, 15'h0FC0, 3'b000, 4'd10},
    // R4: write at step three
    {RD, 15'h0E38, 3'b000, 4'd4}, {RD, 15'h31C7, 3'b000, 4'd4},
    {WR, 15'h03E0, 3'b000, 4'd4}, {RD, 15'h3C1F, 3'b000, 4'd4},
    {RD, 15'h303F, 3'b000, 4'd4}, {RD, 15'h0FC0, 3'b000, 4'd4},
    // R5: wrong read to the first key restarts, recall completes
    {RD, 15'h0E38, 3'b000, 4'd5}, {RD, 15'h31C7, 3'b000, 4'd5},
    {RD, 15'h0E38, 3'b000, 4'd5}, {RD, 15'h31C7, 3'b000, 4'd5},
    {RD, 15'h03E0, 3'b000, 4'd5}, {RD, 15'h3C1F, 3'b000, 4'd5},
    {RD, 15'h303F, 3'b000, 4'd5}, {RD, 15'h0C63, 3'b011, 4'd5},
    {IDL, 15'h0,   3'b001, 4'd8}, {IDL, 15'h0,   3'b001, 4'd8},
    {IDL, 15'h0,   3'b000, 4'd8},
    // R4: write on the sixth access
    {RD, 15'h0E38, 3'b000, 4'd4}, {RD, 15'h31C7, 3'b000, 4'd4},
    {RD, 15'h03E0, 3'b000, 4'd4}, {RD, 15'h3C1F, 3'b000, 4'd4},
    {RD, 15'h303F, 3'b000, 4'd4}, {WR, 15'h0FC0, 3'b000, 4'd4},
    // R5: wrong sixth address
    {RD, 15'h0E38, 3'b000, 4'd5}, {RD, 15'h31C7, 3'b000, 4'd5},
    {RD, 15'h03E0, 3'b000, 4'd5}, {RD, 15'h3C1F, 3'b000, 4'd5},
    {RD, 15'h303F, 3'b000, 4'd5}, {RD, 15'h0FC1, 3'b000, 4'd5},
    // R12: idle gap inside the prefix, store key with bit 14 set
    {RD, 15'h0E38, 3'b000, 4'd12}, {IDL, 15'h0,  3'b000, 4'd12},
    {RD, 15'h31C7, 3'b000, 4'd12}, {RD, 15'h03E0, 3'b000, 4'd12},
    {RD, 15'h3C1F, 3'b000, 4'd12}, {RD, 15'h303F, 3'b000, 4'd12},
    {RD, 15'h4FC0, 3'b101, 4'd12}, {IDL, 15'h0,  3'b001, 4'd8},
    {IDL, 15'h0,   3'b001, 4'd8},  {IDL, 15'h0,  3'b000, 4'd8}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write, acc_oe, seq_busy;
  logic [14:0] acc_addr;
  logic        store_cmd, recall_cmd, bus_float, dq_drive;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  nvcmd_seq_detect u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_addr   (acc_addr),
    .acc_write  (acc_write),
    .acc_oe     (acc_oe),
    .seq_busy   (seq_busy),
    .store_cmd  (store_cmd),
    .recall_cmd (recall_cmd),
    .bus_float  (bus_float),
    .dq_drive   (dq_drive)
  );

  task automatic check(input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  // Starts at a falling edge; drives one access cycle and returns the
  // combinational outputs mid-cycle and the registered ones a cycle later.
  task automatic one_access(input logic [3:0] ctl, input logic [14:0] a,
                            output logic f, output logic d,
                            output logic s, output logic r);
    {acc_valid, acc_write, acc_oe, seq_busy} = ctl;
    acc_addr = a;
    #(CLK_P/4);
    f = bus_float;
    d = dq_drive;
    @(negedge clk);
    s = store_cmd;
    r = recall_cmd;
    {acc_valid, acc_write, acc_oe, seq_busy} = 4'b0000;
    acc_addr = '0;
  endtask

  task automatic prefix5();
    logic f, d, s, r;
    one_access(RD, 15'h0E38, f, d, s, r);
    one_access(RD, 15'h31C7, f, d, s, r);
    one_access(RD, 15'h03E0, f, d, s, r);
    one_access(RD, 15'h3C1F, f, d, s, r);
    one_access(RD, 15'h303F, f, d, s, r);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic f, d, s, r;
    logic [3:0] ctl;
    rst_n = 1'b0;
    {acc_valid, acc_write, acc_oe, seq_busy} = 4'b0000;
    acc_addr = '0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs under reset
    check("R1 store in reset", store_cmd, 1'b0);
    check("R1 recall in reset", recall_cmd, 1'b0);
    check("R1 float in reset", bus_float, 1'b0);
    check("R1 drive in reset", dq_drive, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 store after reset", store_cmd, 1'b0);
    check("R1 float after reset", bus_float, 1'b0);

    for (int i = 0; i < NV; i++) begin
      ctl = VEC[i][25:22];
      one_access(ctl, VEC[i][21:7], f, d, s, r);
      check($sformatf("R%0d row %0d float", VEC[i][3:0], i), f, VEC[i][4]);
      // R9: drive from the access and the expected float
      check($sformatf("R9 row %0d drive", i), d,
            ctl[3] & ~ctl[2] & ctl[1] & ~VEC[i][4]);
      check($sformatf("R%0d row %0d store", VEC[i][3:0], i), s, VEC[i][6]);
      check($sformatf("R%0d row %0d recall", VEC[i][3:0], i), r, VEC[i][5]);
      check($sformatf("R11 row %0d exclusive", i), s & r, 1'b0);
    end

    // R1: reset in the middle of a sequence discards it
    prefix5();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    one_access(RD, 15'h0FC0, f, d, s, r);
    check("R1 reset mid-sequence no store", s, 1'b0);
    check("R1 reset mid-sequence no float", f, 1'b0);

    // R10: busy arriving with the completing access wins
    prefix5();
    one_access(BRD, 15'h0FC0, f, d, s, r);
    check("R10 busy on sixth store", s, 1'b0);
    check("R10 busy on sixth float", f, 1'b1);
    one_access(IDL, 15'h0, f, d, s, r);
    check("R10 busy on sixth released", f, 1'b0);

    // R2: a fresh sequence still works afterwards
    prefix5();
    one_access(RD, 15'h0FC0, f, d, s, r);
    check("R2 store after busy collision", s, 1'b1);
    one_access(IDL, 15'h0, f, d, s, r);
    check("R2 store single cycle", s, 1'b0);
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule